// File: doc/BRIEF.md
# USB Link Status LED Controller

This block turns a handful of event and state signals from a USB device core into the drive level of a single status LED. A person can read the link state from that one light. While the device is not yet configured, the LED is dark and flashes on briefly for each enumeration event. Once the core reports that it is configured, the LED is lit steadily and flashes off briefly for each transfer that the host or the device acknowledged. A suspended bus keeps the LED dark no matter what else happens.

Every flash is stretched by a down-counter to `BLINK_CYCLES` clock cycles, so a one-cycle event becomes a pulse a person can see. A new event during a flash restarts the flash. Flashes are never queued. The block holds three operating modes: suspended, pulse-on and steady. A control module tracks the mode and issues load and clear strobes. A datapath module owns the stretch counter and forms the LED level.

Top module: `usbLinkLed`

## Requirements
- R1: While reset is asserted and directly after it, `ledOut` is 0 and the block is in the unconfigured pulse-on mode.
- R2: In the unconfigured mode, an `enumEvt` pulse sampled at a clock edge drives `ledOut` to 1 from that edge for exactly `BLINK_CYCLES` cycles, and then back to 0.
- R3: While `cfgFlag` is 1 and `suspend` is 0 and no blink is running, `ledOut` is held at 1.
- R4: In the configured mode, a cycle with `xferDone`=1 and `xferAck`=1 drives `ledOut` to 0 from that edge for exactly `BLINK_CYCLES` cycles, and then back to 1.
- R5: A completed transfer without acknowledgment (`xferDone`=1, `xferAck`=0) never starts a blink. An `enumEvt` in the configured mode has no effect, and neither does an acknowledged transfer in the unconfigured mode.
- R6: One cycle after `suspend` is sampled high, `ledOut` is 0. It stays 0 while `suspend` stays high, and every event in that time is ignored.
- R7: An event that arrives while a blink is running restarts the blink, so the blink ends `BLINK_CYCLES` cycles after the latest event.
- R8: After `suspend` falls, the LED follows the mode chosen by the current `cfgFlag` with no blink pending.
- R9: A change of `cfgFlag` switches the mode on the next edge and cancels any running blink. An event sampled in the same cycle as the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enumEvt | input | 1 | One-cycle pulse per enumeration traffic event |
| cfgFlag | input | 1 | Level: device is configured |
| xferDone | input | 1 | One-cycle pulse when a transfer completes (either direction) |
| xferAck | input | 1 | Qualifies `xferDone`: the transfer was acknowledged |
| suspend | input | 1 | Level: bus is suspended |
| ledOut | output | 1 | LED drive level, 1 = lit |

## Verification
The hardest cases to reach are the cycles where a mode change coincides with an event. These are the resume edge with a pending event, a flag change in the middle of a blink, and a retrigger on the last cycle of a blink. Directed sequences with a short `BLINK_CYCLES` place events at every offset inside a blink and at the exact edge where `suspend` or `cfgFlag` toggles. A long stimulus stream from a shift register then mixes all five inputs, with suspend and flag changes kept sparse. Every cycle of that stream is compared against an arithmetic model of the requirements.

// File: rtl/usbLinkLedPkg.sv
package usbLinkLedPkg;

  typedef enum logic [1:0] {
    MODE_SUSP   = 2'd0,
    MODE_PULSE  = 2'd1,
    MODE_STEADY = 2'd2
  } ledMode_t;

  typedef struct packed {
    logic load;
    logic clear;
  } blinkCtl_t;

endpackage

// File: rtl/usbLinkLedCtrl.sv
module usbLinkLedCtrl
  import usbLinkLedPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enumEvt,
  input  logic      cfgFlag,
  input  logic      xferDone,
  input  logic      xferAck,
  input  logic      suspend,
  output ledMode_t  mode,
  output blinkCtl_t ctl
);

  ledMode_t modeReg;
  ledMode_t nextMode;
  logic     modeChange;
  logic     trigger;

  always_comb begin
    if (suspend)      nextMode = MODE_SUSP;
    else if (cfgFlag) nextMode = MODE_STEADY;
    else              nextMode = MODE_PULSE;
  end

  assign modeChange = (nextMode != modeReg);

  always_comb begin
    unique case (modeReg)
      MODE_PULSE:  trigger = enumEvt;
      MODE_STEADY: trigger = xferDone && xferAck;
      default:     trigger = 1'b0;
    endcase
  end

  always_comb begin
    ctl.clear = modeChange || suspend;
    ctl.load  = trigger && !ctl.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= MODE_PULSE;
    else       modeReg <= nextMode;
  end

  assign mode = modeReg;

endmodule

// File: rtl/usbLinkLedTimer.sv
module usbLinkLedTimer
  import usbLinkLedPkg::*;
#(
  parameter int BLINK_CYCLES = 2_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  ledMode_t  mode,
  input  blinkCtl_t ctl,
  output logic      ledOut
);

  localparam int CNT_W = $clog2(BLINK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BLINK_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.clear) cnt <= '0;
    else if (ctl.load)  cnt <= LOAD_VAL;
    else if (busy)      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  always_comb begin
    unique case (mode)
      MODE_PULSE:  ledOut = busy;
      MODE_STEADY: ledOut = !busy;
      default:     ledOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/usbLinkLed.sv
module usbLinkLed
  import usbLinkLedPkg::*;
#(
  parameter int BLINK_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enumEvt,
  input  logic cfgFlag,
  input  logic xferDone,
  input  logic xferAck,
  input  logic suspend,
  output logic ledOut
);

  ledMode_t  mode;
  blinkCtl_t ctl;

  usbLinkLedCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enumEvt  (enumEvt),
    .cfgFlag  (cfgFlag),
    .xferDone (xferDone),
    .xferAck  (xferAck),
    .suspend  (suspend),
    .mode     (mode),
    .ctl      (ctl)
  );

  usbLinkLedTimer #(
    .BLINK_CYCLES (BLINK_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .ctl    (ctl),
    .ledOut (ledOut)
  );

endmodule

// File: rtl/usbLinkLedChk.sv
module usbLinkLedChk (
  input logic clk,
  input logic rstN,
  input logic enumEvt,
  input logic cfgFlag,
  input logic xferDone,
  input logic xferAck,
  input logic suspend,
  input logic ledOut
);

  // R6: a sampled suspend darkens the LED on the next cycle
  a_r6_suspend_dark: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> !ledOut);

  // R2: enumeration event in stable unconfigured mode lights the LED
  a_r2_enum_lights: assert property (@(posedge clk) disable iff (!rstN)
    (enumEvt && !cfgFlag && !suspend && $past(!cfgFlag) && $past(!suspend))
    |=> ledOut);

  // R4: acknowledged transfer in stable configured mode darkens the LED
  a_r4_ack_dark: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferAck && cfgFlag && !suspend && $past(cfgFlag) && $past(!suspend))
    |=> !ledOut);

  // R3, R5: lit configured LED stays lit without an acknowledged transfer
  a_r5_steady_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ledOut && cfgFlag && !suspend && $past(cfgFlag) && $past(!suspend)
     && !(xferDone && xferAck))
    |=> ledOut);

  // R9: a change of the configured flag cancels any blink
  a_r9_cfg_rise_lit: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgFlag) && !suspend) |=> ledOut);

  a_r9_cfg_fall_dark: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cfgFlag) && !suspend) |=> !ledOut);

endmodule

bind usbLinkLed usbLinkLedChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enumEvt  (enumEvt),
  .cfgFlag  (cfgFlag),
  .xferDone (xferDone),
  .xferAck  (xferAck),
  .suspend  (suspend),
  .ledOut   (ledOut)
);

// File: tb/usbLinkLed_bench.sv
module usbLinkLed_bench;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enumEvt = 1'b0;
  logic cfgFlag = 1'b0;
  logic xferDone = 1'b0;
  logic xferAck = 1'b0;
  logic suspend = 1'b0;
  logic ledOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state: 0 suspended, 1 pulse-on, 2 steady
  int expMode = 1;
  int expRem = 0;

  always #10 clk = ~clk;

  usbLinkLed #(.BLINK_CYCLES(N)) u_usbLinkLed (
    .clk      (clk),
    .rstN     (rstN),
    .enumEvt  (enumEvt),
    .cfgFlag  (cfgFlag),
    .xferDone (xferDone),
    .xferAck  (xferAck),
    .suspend  (suspend),
    .ledOut   (ledOut)
  );

  function automatic bit expLed();
    if (expMode == 1) return expRem > 0;
    if (expMode == 2) return expRem == 0;
    return 1'b0;
  endfunction

  task automatic check(input bit exp, input string tag);
    total++;
    if (ledOut !== exp) begin
      bad++;
      $display("FAIL %s t=%0t ledOut=%b expected=%b", tag, $time, ledOut, exp);
    end
  endtask

  // apply inputs for one clock, advance model, check away from the edge
  task automatic step(input bit e, input bit c, input bit d, input bit a,
                      input bit s, input string tag);
    int newMode;
    bit trig;
    enumEvt = e; cfgFlag = c; xferDone = d; xferAck = a; suspend = s;
    @(posedge clk);
    newMode = s ? 0 : (c ? 2 : 1);
    trig = (expMode == 1) ? e : ((expMode == 2) ? (d && a) : 1'b0);
    if (newMode != expMode || s) expRem = 0;
    else if (trig) expRem = N;
    else if (expRem > 0) expRem--;
    expMode = newMode;
    #5;
    check(expLed(), tag);
  endtask

  task automatic idle(input int k, input bit c, input bit s, input string tag);
    for (int i = 0; i < k; i++) step(0, c, 0, 0, s, tag);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    bit c;
    bit s;
    // R1: reset state
    #15;
    check(1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    #5;
    check(1'b0, "R1 after reset");
    idle(2, 0, 0, "R1 idle");

    // R2: stretched on-pulse, exact length
    step(1, 0, 0, 0, 0, "R2 event");
    idle(N + 2, 0, 0, "R2 stretch");

    // R7: retrigger at every offset inside a blink
    for (int off = 0; off < N; off++) begin
      step(1, 0, 0, 0, 0, "R7 first");
      idle(off, 0, 0, "R7 gap");
      step(1, 0, 0, 0, 0, "R7 restart");
      idle(N + 1, 0, 0, "R7 tail");
    end

    // R5: ack transfers do nothing while unconfigured
    step(0, 0, 1, 1, 0, "R5 xfer unconfigured");
    idle(2, 0, 0, "R5 idle");

    // R9: event on the edge of configuration is dropped
    step(1, 1, 0, 0, 0, "R9 change with event");
    idle(2, 1, 0, "R3 steady");

    // R4: off-blink on ack, exact length
    step(0, 1, 1, 1, 0, "R4 ack");
    idle(N + 2, 1, 0, "R4 stretch");

    // R5: unacked transfer and enum event do nothing when configured
    step(0, 1, 1, 0, 0, "R5 nak");
    step(1, 1, 0, 0, 0, "R5 enum configured");
    idle(2, 1, 0, "R5 idle");

    // R7 in configured mode
    step(0, 1, 1, 1, 0, "R7 ack");
    idle(N - 1, 1, 0, "R7 gap");
    step(0, 1, 1, 1, 0, "R7 ack last");
    idle(N + 1, 1, 0, "R7 tail");

    // R9: flag drop mid-blink cancels it
    step(0, 1, 1, 1, 0, "R9 ack");
    step(0, 0, 0, 0, 0, "R9 unconfigure");
    idle(2, 0, 0, "R9 pulse mode");

    // R6: suspend with events, R8 resume into each mode
    step(1, 0, 0, 0, 0, "R6 pre");
    step(1, 0, 1, 1, 1, "R6 enter");
    step(1, 0, 1, 1, 1, "R6 events");
    step(0, 1, 1, 1, 1, "R6 events cfg");
    step(1, 1, 1, 1, 0, "R8 resume event");
    idle(3, 1, 0, "R8 steady");
    step(0, 1, 1, 1, 0, "R8 ack");
    step(0, 1, 0, 0, 1, "R6 mid blink");
    idle(2, 1, 1, "R6 held");
    idle(N + 1, 0, 0, "R8 unconfigured");

    // sweep: shift-register stimulus against the model
    lfsr = 16'hACE1;
    c = 0;
    s = 0;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:3] == 5'd0) c = ~c;
      if (lfsr[12:8] == 5'd31) s = ~s;
      step(lfsr[0] & lfsr[1], c, lfsr[2], lfsr[14], s, "R2/R4/R5/R6/R7/R8/R9 sweep");
    end

    // reset mid-operation returns to R1 state
    step(0, 1, 0, 0, 0, "R3 before reset");
    #3;
    rstN = 1'b0;
    #2;
    check(1'b0, "R1 reset mid-run");
    @(negedge clk);
    cfgFlag = 1'b0;
    rstN = 1'b1;
    expMode = 1;
    expRem = 0;
    idle(2, 0, 0, "R1 post reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule